// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Slave

This block is the far end of a two-wire serial link that software drives by writing a system control register. One bit of that register is a serial clock and another is a data bit. Each write to the register reaches the block as a one-cycle `ctl_wr` strobe that carries the two bit levels. The block only acts when the clock bit goes from high to low between two writes. A frame has sixteen such falling edges. The first eight carry a command byte and the last eight carry a data byte, most significant bit first in both cases.

The command byte selects one of several windows in a single byte-wide address space:

- reading or writing a 32-byte battery-backed scratch RAM,
- reading one of six BCD time-of-day fields,
- reading a status byte or a control byte,
- writing the control byte.

For read commands, the block returns one bit per data-phase edge on `rd_bit`, which software reads back through the register read path. A control write with its clear bit set removes two status flags and sends a single-cycle pulse to the interrupt flag of the clock.

A BCD calendar counter (seconds, minutes, hours, day, month, year) advances once per `sec_tick` pulse. A `frame_rst` input, asserted when the device is deselected, returns the serial engine to the start of a frame.

Top module: `rtc_serial_if`

## Requirements
- R1: A falling serial edge is a cycle with `ctl_wr` high and `ctl_sclk` low, where the clock level captured by the previous `ctl_wr` write was high. The captured level is low after reset. Writes that keep the clock level, rising writes, and `ctl_sclk` changes without `ctl_wr` change no frame state.
- R2: The first eight falling edges of a frame shift `ctl_sdata` into the command byte, MSB first.
- R3: Edges nine to sixteen form the data phase, MSB first. After the sixteenth edge, further edges are ignored until `frame_rst`.
- R4: `frame_rst` takes priority over an edge in the same cycle. From the next cycle, the phase, the command, `rd_bit` and `rd_active` are all zero.
- R5: Commands 0x00–0x1F read RAM byte cmd[4:0]. In the cycle after data edge k (k = 0..7), `rd_bit` shows bit 7−k of the byte.
- R6: Commands 0x80–0x9F write the data byte to RAM byte cmd[4:0] on the sixteenth edge. All RAM bytes reset to 0x00.
- R7: Command 0x30 reads the status byte, which resets to 0x90. Command 0x31 reads the control byte, which resets to 0x00.
- R8: Commands 0x20–0x25 read seconds, minutes, hours, day, month and year, in that order. Each field is BCD with tens in bits 7:4 and units in bits 3:0. Commands 0x26–0x2F read 0x00.
- R9: Command 0xB1 writes the control byte. If data bit 2 is set, status bits 4 and 3 are cleared, and `irq_flag_clr` is high for exactly the one cycle after the sixteenth edge. Otherwise `irq_flag_clr` stays low.
- R10: Each `sec_tick` cycle advances the calendar, which resets to 00:00:00, day 01, month 01, year 00. Seconds and minutes wrap 59→00 with a carry. Hours wrap 23→00 with a carry, day wraps 31→01, month wraps 12→01 and year wraps 99→00. With no tick, the fields hold.
- R11: Commands with bit 7 clear that fall in no defined window (0x32–0x7F) read as all-zero bits.
- R12: `rd_active` rises at the first data edge of commands with bit 7 clear and stays low for commands with bit 7 set. In both cases `rd_bit` is 0 for commands with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | One-cycle strobe: the control register was written |
| ctl_sclk | input | 1 | Serial clock level carried by the write |
| ctl_sdata | input | 1 | Serial data level carried by the write |
| frame_rst | input | 1 | Device deselect; restarts the frame |
| sec_tick | input | 1 | One-second advance pulse for the calendar |
| rd_bit | output | 1 | Data bit returned to the register read path |
| rd_active | output | 1 | High while the block drives `rd_bit` for a read command |
| irq_flag_clr | output | 1 | One-cycle clear pulse for the clock interrupt flag |

## Verification
The bench goes after edge qualification first. It surrounds every real falling edge with rising writes, writes that keep the level, and `ctl_sclk` toggles without a strobe. A design that shifts on any write, or on the raw input level, would decode a different command and return the wrong byte.

It sends extra edges after the sixteenth, carrying ones on the data line. A counter that does not saturate would shift garbage into a later RAM write or change `rd_bit`.

It deselects in the middle of a command. A design that kept the partial command would misread the next status frame.

It checks the clear pulse of the control write with the trigger bit both set and clear. It walks the calendar across the seconds, minutes and hours rollovers into the next day, where a missed BCD carry or a wrong limit shows up as a bad field value.

// File: rtl/rtc_pkg.sv
// Shared constants, types and pure functions for the serial clock slave.
// Assumes 8-bit commands and a 16-edge frame; time fields are 8-bit BCD.
package rtc_pkg;

    localparam int CMD_W           = 8;
    localparam int NUM_TIME_FIELDS = 6;

    typedef logic [CMD_W-1:0] byte_t;
    typedef byte_t [NUM_TIME_FIELDS-1:0] time_vec_t;

    localparam byte_t CMD_STATUS_RD  = 8'h30;
    localparam byte_t CMD_CONTROL_RD = 8'h31;
    localparam byte_t CMD_CONTROL_WR = 8'hB1;
    localparam byte_t STATUS_RESET   = 8'h90;
    localparam byte_t STATUS_CLR_MSK = 8'h18;
    localparam int    CTRL_CLR_BIT   = 2;

    // Address windows the command byte can select.
    typedef enum logic [2:0] {
        WIN_RAM_RD,
        WIN_TIME,
        WIN_STATUS,
        WIN_CONTROL,
        WIN_RAM_WR,
        WIN_CTRL_WR,
        WIN_NONE
    } cmd_win_e;

    // Map a command byte onto its window.
    function automatic cmd_win_e decode_cmd(input byte_t c);
        if (c[7:5] == 3'b000)       return WIN_RAM_RD;
        else if (c[7:4] == 4'h2)    return WIN_TIME;
        else if (c == CMD_STATUS_RD)  return WIN_STATUS;
        else if (c == CMD_CONTROL_RD) return WIN_CONTROL;
        else if (c[7:5] == 3'b100)  return WIN_RAM_WR;
        else if (c == CMD_CONTROL_WR) return WIN_CTRL_WR;
        return WIN_NONE;
    endfunction

    // Lowest legal BCD value of calendar field i (sec, min, hr, day, mon, yr).
    function automatic byte_t field_min(input int i);
        case (i)
            3, 4:    return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Highest legal BCD value of calendar field i.
    function automatic byte_t field_max(input int i);
        case (i)
            0, 1:    return 8'h59;
            2:       return 8'h23;
            3:       return 8'h31;
            4:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    // One BCD increment with wrap from hi back to lo.
    function automatic byte_t bcd_step(input byte_t v, input byte_t lo, input byte_t hi);
        if (v == hi)              return lo;
        else if (v[3:0] == 4'd9)  return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_frame.sv
// Serial frame engine: qualifies falling serial-clock writes, shifts in the
// command and data bytes MSB first, and returns one read bit per data edge.
// Assumes ctl_wr is a single-cycle strobe per register write; frame_rst
// has priority over any edge in the same cycle.
module rtc_frame
    import rtc_pkg::*;
#(
    parameter int PHASE_W = 5
)
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic               ctl_sclk,
    input  logic               ctl_sdata,
    input  logic               frame_rst,
    input  byte_t              rd_byte,
    output byte_t              cmd_q,
    output logic [PHASE_W-1:0] phase_q,
    output logic               wr_fire,
    output byte_t              wr_data,
    output logic               rd_bit,
    output logic               rd_active
);

    localparam logic [PHASE_W-1:0] CMD_END   = PHASE_W'(CMD_W);
    localparam logic [PHASE_W-1:0] FRAME_END = PHASE_W'(2 * CMD_W);
    localparam logic [PHASE_W-1:0] LAST_EDGE = PHASE_W'(2 * CMD_W - 1);

    logic             sclk_last;
    logic [CMD_W-2:0] val_q;
    logic             fall;
    logic             in_cmd;
    logic             in_data;
    logic [2:0]       bit_idx;

    assign fall    = ctl_wr && sclk_last && !ctl_sclk;
    assign in_cmd  = phase_q < CMD_END;
    assign in_data = (phase_q >= CMD_END) && (phase_q < FRAME_END);
    assign bit_idx = 3'd7 - phase_q[2:0];
    assign wr_data = {val_q, ctl_sdata};
    assign wr_fire = fall && (phase_q == LAST_EDGE) && !frame_rst;

    // Remember the clock level carried by the latest register write.
    always_ff @(posedge clk) begin
        if (!rst_n)      sclk_last <= 1'b0;
        else if (ctl_wr) sclk_last <= ctl_sclk;
    end

    // Advance the phase and shift the command or data byte on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_rst) begin
            phase_q <= '0;
            cmd_q   <= '0;
            val_q   <= '0;
        end else if (fall && in_cmd) begin
            cmd_q   <= {cmd_q[CMD_W-2:0], ctl_sdata};
            phase_q <= phase_q + 1'b1;
        end else if (fall && in_data) begin
            val_q   <= {val_q[CMD_W-3:0], ctl_sdata};
            phase_q <= phase_q + 1'b1;
        end
    end

    // Present the next bit of the selected byte during read commands.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_rst) begin
            rd_bit    <= 1'b0;
            rd_active <= 1'b0;
        end else if (fall && in_data) begin
            rd_active <= !cmd_q[CMD_W-1];
            rd_bit    <= !cmd_q[CMD_W-1] && rd_byte[bit_idx];
        end
    end

endmodule

// File: rtl/rtc_regfile.sv
// Register file behind the frame engine: scratch RAM, status and control
// bytes, the read multiplexer over all windows, and the flag-clear pulse.
// Assumes RAM_BYTES is a power of two no larger than 32 (the RAM window).
module rtc_regfile
    import rtc_pkg::*;
#(
    parameter int RAM_BYTES = 32
)
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_fire,
    input  byte_t     cmd,
    input  byte_t     wr_data,
    input  time_vec_t time_bcd,
    output byte_t     rd_byte,
    output logic      irq_clr
);

    localparam int RAM_AW = $clog2(RAM_BYTES);

    byte_t             ram_q [RAM_BYTES];
    byte_t             status_q;
    byte_t             control_q;
    cmd_win_e          win;
    logic [RAM_AW-1:0] ram_idx;
    logic              ctl_hit;

    assign win     = decode_cmd(cmd);
    assign ram_idx = cmd[RAM_AW-1:0];
    assign ctl_hit = wr_fire && (win == WIN_CTRL_WR);

    // Scratch RAM: cleared on reset, written at the end of a write frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_BYTES; i++) ram_q[i] <= '0;
        end else if (wr_fire && (win == WIN_RAM_WR)) begin
            ram_q[ram_idx] <= wr_data;
        end
    end

    // Status and control bytes; a control write may drop two status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q  <= STATUS_RESET;
            control_q <= '0;
        end else if (ctl_hit) begin
            control_q <= wr_data;
            if (wr_data[CTRL_CLR_BIT]) status_q <= status_q & ~STATUS_CLR_MSK;
        end
    end

    // One-cycle clear pulse toward the clock interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_clr <= 1'b0;
        else        irq_clr <= ctl_hit && wr_data[CTRL_CLR_BIT];
    end

    // Select the byte that a read command returns; undefined reads give zero.
    always_comb begin
        rd_byte = '0;
        case (win)
            WIN_RAM_RD:  rd_byte = ram_q[ram_idx];
            WIN_TIME:    if (cmd[3:0] < 4'(NUM_TIME_FIELDS)) rd_byte = time_bcd[cmd[2:0]];
            WIN_STATUS:  rd_byte = status_q;
            WIN_CONTROL: rd_byte = control_q;
            default:     rd_byte = '0;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_clock.sv
// BCD calendar: a chain of six rolling fields advanced by a one-second tick.
// Assumes every month has 31 days; the year wraps after 99.
module rtc_bcd_clock
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    output time_vec_t time_bcd
);

    logic [NUM_TIME_FIELDS-1:0] step_en;

    assign step_en[0] = sec_tick;

    for (genvar i = 0; i < NUM_TIME_FIELDS; i++) begin : g_field
        localparam byte_t LO = field_min(i);
        localparam byte_t HI = field_max(i);
        byte_t cnt_q;

        // Step this field when all lower fields are wrapping.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q <= LO;
            else if (step_en[i]) cnt_q <= bcd_step(cnt_q, LO, HI);
        end

        assign time_bcd[i] = cnt_q;

        if (i < NUM_TIME_FIELDS - 1) begin : g_carry
            assign step_en[i+1] = step_en[i] && (cnt_q == HI);
        end
    end

endmodule

// File: rtl/rtc_serial_if.sv
// Top of the serial clock slave: frame engine, register file and calendar.
// Assumes the control-register write strobe and bit levels arrive already
// synchronous to clk.
module rtc_serial_if
    import rtc_pkg::*;
#(
    parameter int RAM_BYTES = 32,
    parameter int PHASE_W   = 5
)
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_sclk,
    input  logic ctl_sdata,
    input  logic frame_rst,
    input  logic sec_tick,
    output logic rd_bit,
    output logic rd_active,
    output logic irq_flag_clr
);

    byte_t              cmd;
    logic [PHASE_W-1:0] phase;
    logic               wr_fire;
    byte_t              wr_data;
    byte_t              rd_byte;
    time_vec_t          time_bcd;

    rtc_frame #(.PHASE_W(PHASE_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_sclk  (ctl_sclk),
        .ctl_sdata (ctl_sdata),
        .frame_rst (frame_rst),
        .rd_byte   (rd_byte),
        .cmd_q     (cmd),
        .phase_q   (phase),
        .wr_fire   (wr_fire),
        .wr_data   (wr_data),
        .rd_bit    (rd_bit),
        .rd_active (rd_active)
    );

    rtc_regfile #(.RAM_BYTES(RAM_BYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_fire  (wr_fire),
        .cmd      (cmd),
        .wr_data  (wr_data),
        .time_bcd (time_bcd),
        .rd_byte  (rd_byte),
        .irq_clr  (irq_flag_clr)
    );

    rtc_bcd_clock u_clock (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_tick (sec_tick),
        .time_bcd (time_bcd)
    );

endmodule

// File: rtl/rtc_serial_if_chk.sv
// Property checker for rtc_serial_if, attached through bind.
module rtc_serial_if_chk
    import rtc_pkg::*;
#(
    parameter int PHASE_W = 5
)
(
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_wr,
    input logic               ctl_sclk,
    input logic               frame_rst,
    input logic               sec_tick,
    input logic               rd_active,
    input logic               irq_flag_clr,
    input logic [PHASE_W-1:0] phase,
    input byte_t              cmd,
    input time_vec_t          time_bcd
);

    localparam logic [PHASE_W-1:0] FULL  = PHASE_W'(2 * CMD_W);
    localparam logic [PHASE_W-1:0] DATA1 = PHASE_W'(CMD_W + 1);

    // R1: without a low-level write the frame state does not move
    a_r1_no_edge_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_rst && !(ctl_wr && !ctl_sclk)) |=> ($stable(phase) && $stable(cmd)));

    // R3: phase never passes the end of frame
    a_r3_phase_cap: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= FULL);

    // R3: a finished frame stays finished until deselect
    a_r3_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == FULL && !frame_rst) |=> (phase == FULL));

    // R4: deselect clears the frame state
    a_r4_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_rst |=> (phase == '0 && cmd == '0 && !rd_active));

    // R9: clear pulse lasts a single cycle
    a_r9_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag_clr |=> !irq_flag_clr);

    // R12: read drive only after a data edge
    a_r12_active_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> (phase >= DATA1 && !cmd[CMD_W-1]));

    // R10: calendar holds without a tick
    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> $stable(time_bcd));

    // R10: seconds stay a legal BCD value
    a_r10_seconds_range: assert property (@(posedge clk) disable iff (!rst_n)
        (time_bcd[0] <= 8'h59 && time_bcd[0][3:0] <= 4'd9));

    // R10: month stays within 01..12
    a_r10_month_range: assert property (@(posedge clk) disable iff (!rst_n)
        (time_bcd[4] >= 8'h01 && time_bcd[4] <= 8'h12));

    // R10: day stays within 01..31
    a_r10_day_range: assert property (@(posedge clk) disable iff (!rst_n)
        (time_bcd[3] >= 8'h01 && time_bcd[3] <= 8'h31));

endmodule

bind rtc_serial_if rtc_serial_if_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_sclk     (ctl_sclk),
    .frame_rst    (frame_rst),
    .sec_tick     (sec_tick),
    .rd_active    (rd_active),
    .irq_flag_clr (irq_flag_clr),
    .phase        (phase),
    .cmd          (cmd),
    .time_bcd     (time_bcd)
);

// File: tb/rtc_serial_if_test.sv
module rtc_serial_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic ctl_sclk = 1'b0;
    logic ctl_sdata = 1'b0;
    logic frame_rst = 1'b0;
    logic sec_tick = 1'b0;
    logic rd_bit, rd_active, irq_flag_clr;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_serial_if uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sclk(ctl_sclk),
        .ctl_sdata(ctl_sdata), .frame_rst(frame_rst), .sec_tick(sec_tick),
        .rd_bit(rd_bit), .rd_active(rd_active), .irq_flag_clr(irq_flag_clr)
    );

    // Count clear pulses, sampled away from the active edge.
    always @(negedge clk) if (rst_n && irq_flag_clr) irq_cnt++;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ctl_wr = 1'b0; ctl_sclk = 1'b0; frame_rst = 1'b0; sec_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_write(input logic sc, input logic sd);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_sclk = sc; ctl_sdata = sd;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic edge_bit(input logic b, output logic rb, output logic ra);
        reg_write(1'b1, b);
        reg_write(1'b0, b);
        rb = rd_bit;
        ra = rd_active;
    endtask

    task automatic deselect();
        @(negedge clk); frame_rst = 1'b1;
        @(negedge clk); frame_rst = 1'b0;
    endtask

    task automatic frame(input logic [7:0] c, input logic [7:0] d,
                         output logic [7:0] rbyte, output logic ra);
        logic rb;
        for (int i = 7; i >= 0; i--) edge_bit(c[i], rb, ra);
        for (int i = 7; i >= 0; i--) begin
            edge_bit(d[i], rb, ra);
            rbyte[i] = rb;
        end
    endtask

    task automatic read_byte(input logic [7:0] c, output logic [7:0] v, output logic ra);
        frame(c, 8'h00, v, ra);
        deselect();
    endtask

    task automatic write_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] v; logic ra;
        frame(c, d, v, ra);
        deselect();
    endtask

    task automatic ticks(input int n);
        @(negedge clk); sec_tick = 1'b1;
        repeat (n) @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic t_reset_state();
        check("reset rd_bit", rd_bit, 0);
        check("reset rd_active", rd_active, 0);
        check("reset irq_flag_clr", irq_flag_clr, 0);
    endtask

    task automatic t_status_control();
        logic [7:0] v; logic ra;
        read_byte(8'h30, v, ra);
        check("R7 status reset 0x90", v, 8'h90);
        check("R12 read drives rd_active", ra, 1);
        read_byte(8'h31, v, ra);
        check("R7 control reset 0x00", v, 8'h00);
    endtask

    task automatic t_ram();
        logic [7:0] v; logic ra; logic [7:0] wv;
        read_byte(8'h05, v, ra);
        check("R6 RAM resets to zero", v, 8'h00);
        frame(8'h85, 8'hA5, wv, ra);
        deselect();
        check("R12 write command keeps rd_active low", ra, 0);
        check("R12 write command rd_bit low", wv, 8'h00);
        write_byte(8'h9F, 8'h3C);
        read_byte(8'h05, v, ra);
        check("R5 R6 RAM byte 5 MSB first", v, 8'hA5);
        read_byte(8'h1F, v, ra);
        check("R2 R5 RAM byte 31", v, 8'h3C);
        read_byte(8'h06, v, ra);
        check("R6 neighbour byte untouched", v, 8'h00);
    endtask

    task automatic t_ignored_writes();
        logic [7:0] c; logic [7:0] v; logic rb; logic ra;
        c = 8'h30;
        for (int i = 7; i >= 0; i--) begin
            reg_write(1'b1, ~c[i]);
            reg_write(1'b1, c[i]);
            @(negedge clk); ctl_sclk = 1'b1; ctl_sdata = ~c[i];
            @(negedge clk); ctl_sclk = 1'b0;
            reg_write(1'b0, c[i]);
            reg_write(1'b0, ~c[i]);
        end
        for (int i = 7; i >= 0; i--) begin
            edge_bit(1'b0, rb, ra);
            v[i] = rb;
        end
        deselect();
        check("R1 only qualified falling writes count", v, 8'h90);
    endtask

    task automatic t_frame_saturation();
        logic [7:0] v; logic rb; logic ra;
        frame(8'h86, 8'h5A, v, ra);
        for (int i = 0; i < 8; i++) edge_bit(1'b1, rb, ra);
        deselect();
        read_byte(8'h06, v, ra);
        check("R3 extra edges after write frame ignored", v, 8'h5A);
        frame(8'h30, 8'h00, v, ra);
        for (int i = 0; i < 4; i++) edge_bit(1'b1, rb, ra);
        check("R3 rd_bit holds after frame end", rb, 0);
        check("R3 rd_active holds after frame end", ra, 1);
        deselect();
    endtask

    task automatic t_deselect_mid();
        logic [7:0] v; logic rb; logic ra;
        edge_bit(1'b1, rb, ra);
        edge_bit(1'b0, rb, ra);
        edge_bit(1'b1, rb, ra);
        deselect();
        check("R4 deselect clears rd_active", rd_active, 0);
        read_byte(8'h30, v, ra);
        check("R4 partial command discarded", v, 8'h90);
    endtask

    task automatic t_undefined();
        logic [7:0] v; logic ra;
        read_byte(8'h40, v, ra);
        check("R11 command 0x40 reads zero", v, 8'h00);
        check("R11 command 0x40 drives", ra, 1);
        read_byte(8'h7F, v, ra);
        check("R11 command 0x7F reads zero", v, 8'h00);
        read_byte(8'h32, v, ra);
        check("R11 command 0x32 reads zero", v, 8'h00);
    endtask

    task automatic t_control_write();
        logic [7:0] v; logic ra; int base;
        base = irq_cnt;
        write_byte(8'hB1, 8'h01);
        check("R9 no pulse without bit 2", irq_cnt - base, 0);
        read_byte(8'h30, v, ra);
        check("R9 status kept without bit 2", v, 8'h90);
        read_byte(8'h31, v, ra);
        check("R9 control written", v, 8'h01);
        base = irq_cnt;
        write_byte(8'hB1, 8'h04);
        check("R9 single clear pulse", irq_cnt - base, 1);
        read_byte(8'h30, v, ra);
        check("R9 status bits 4:3 cleared", v, 8'h80);
        read_byte(8'h31, v, ra);
        check("R9 control takes 0x04", v, 8'h04);
    endtask

    task automatic t_time_fields();
        logic [7:0] v; logic ra;
        do_reset();
        ticks(75);
        read_byte(8'h20, v, ra); check("R8 seconds BCD", v, 8'h15);
        read_byte(8'h21, v, ra); check("R8 minutes BCD", v, 8'h01);
        read_byte(8'h22, v, ra); check("R8 hours BCD", v, 8'h00);
        read_byte(8'h23, v, ra); check("R8 day BCD", v, 8'h01);
        read_byte(8'h24, v, ra); check("R8 month BCD", v, 8'h01);
        read_byte(8'h25, v, ra); check("R8 year BCD", v, 8'h00);
        read_byte(8'h26, v, ra); check("R8 unassigned 0x26", v, 8'h00);
        read_byte(8'h2F, v, ra); check("R8 unassigned 0x2F", v, 8'h00);
    endtask

    task automatic t_rollover();
        logic [7:0] v; logic ra;
        do_reset();
        ticks(59);
        read_byte(8'h20, v, ra); check("R10 seconds reach 59", v, 8'h59);
        ticks(1);
        read_byte(8'h20, v, ra); check("R10 seconds wrap", v, 8'h00);
        read_byte(8'h21, v, ra); check("R10 minute carry", v, 8'h01);
        ticks(86339);
        read_byte(8'h20, v, ra); check("R10 end of day seconds", v, 8'h59);
        read_byte(8'h21, v, ra); check("R10 end of day minutes", v, 8'h59);
        read_byte(8'h22, v, ra); check("R10 end of day hours", v, 8'h23);
        ticks(1);
        read_byte(8'h22, v, ra); check("R10 hours wrap", v, 8'h00);
        read_byte(8'h21, v, ra); check("R10 minutes wrap", v, 8'h00);
        read_byte(8'h23, v, ra); check("R10 day carry", v, 8'h02);
        read_byte(8'h24, v, ra); check("R10 month unchanged", v, 8'h01);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_status_control();
        t_ram();
        t_ignored_writes();
        t_frame_saturation();
        t_deselect_mid();
        t_undefined();
        t_control_write();
        t_time_fields();
        t_rollover();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(negedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule